// File: doc/BRIEF.md
# Per-Field Alarm Comparator

This block stores six alarm bytes, one for each of seconds, minutes, hours, weekday, day of month and month. It compares them against the live BCD time fields that a separate time-counter core supplies. Each alarm byte has its own compare-enable bit in bit 7 above a 7-bit BCD value in bits 6:0. Any subset of the six fields can therefore take part in the match. The month field uses the 1 to 12 range that the counter core supplies.

The match is evaluated only on the cycle in which the counter core pulses its seconds-update strobe. If every enabled field equals its live time field at that moment, a sticky alarm flag is set. The flag goes out as an interrupt when the alarm interrupt enable is set. Software reaches the alarm bytes and one control byte through a simple byte-wide register port. It clears the flag and the enable before it reprograms the alarm values.

Register map: addresses 0 to 5 are the alarm bytes for seconds, minutes, hours, weekday, day of month and month, in that order. Address 6 is the control byte, with the alarm flag in bit 0 and the alarm interrupt enable in bit 3. Address 7 reads as zero.

Top module: `alarm_cmp`

## Requirements
- R1: After reset all six alarm bytes read 0x00, the control byte reads 0x00 and `alarmIrq` is low.
- R2: A write to address 0 to 5 stores all 8 bits of `wrData`, and a read of that address returns them unchanged.
- R3: The control byte at address 6 reads the flag in bit 0 and the interrupt enable in bit 3. Every other bit reads 0, whatever value was written.
- R4: When `secTick` is high and every alarm byte whose bit 7 is 1 has bits 6:0 equal to the matching 7-bit time field, the flag reads 1 from the next clock cycle on.
- R5: An alarm byte with bit 7 = 0 takes no part in the comparison: its value and its time field do not affect whether the flag is set.
- R6: The flag is never set in a cycle without `secTick`, even while all enabled fields match.
- R7: If all six enable bits are 0, the flag is never set.
- R8: Writing the control byte with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged, and in both cases bit 3 takes the written value.
- R9: If a set condition (R4) and a clearing control write (R8) fall in the same cycle, the flag ends up set.
- R10: `alarmIrq` is high exactly when the flag and the interrupt enable are both 1.
- R11: If any enabled field differs from its time field while `secTick` is high, the flag is not set by that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0-5 alarm bytes, 6 control) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| timeFields | input | 42 | Live BCD time; field i in bits 7i+6:7i (0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month) |
| secTick | input | 1 | One-cycle pulse from the counter core at each seconds update |
| alarmIrq | output | 1 | Alarm interrupt, flag AND enable |

## Verification
The main sweep goes through all 64 combinations of the six enable bits. Under each combination it gives the comparator a full match and then six single-field mismatches, one per field. The full match separates "some field enabled" from "none enabled". Each single-field mismatch shows whether that one field really drives the decision when enabled and is really ignored when disabled. Targeted cases then present a standing match with no strobe, a strobe together with a clearing write, and the four flag and enable combinations on the interrupt output.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int VAL_W      = 7;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int EN_BIT     = VAL_W;
  localparam int CTRL_ADDR  = NUM_FIELDS;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;
  localparam int TIME_W     = NUM_FIELDS * VAL_W;
  localparam int REGS_W     = NUM_FIELDS * DATA_W;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldLoad;
    logic [DATA_W-1:0]     loadByte;
  } fieldStrobe_t;
endpackage

// File: rtl/alarm_field_dp.sv
module alarm_field_dp
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fieldStrobe_t      strobe,
  input  logic [TIME_W-1:0] timeFields,
  output logic [REGS_W-1:0] fieldRegs,
  output logic              anyEnabled,
  output logic              allHit
);
  logic [NUM_FIELDS-1:0] fieldHit;
  logic [NUM_FIELDS-1:0] fieldEn;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gField
    logic [DATA_W-1:0] alarmByte;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmByte <= '0;
      end else if (strobe.fieldLoad[i]) begin
        alarmByte <= strobe.loadByte;
      end
    end

    assign fieldRegs[i*DATA_W +: DATA_W] = alarmByte;
    assign fieldEn[i]  = alarmByte[EN_BIT];
    assign fieldHit[i] = !alarmByte[EN_BIT] ||
                         (alarmByte[VAL_W-1:0] == timeFields[i*VAL_W +: VAL_W]);
  end

  assign anyEnabled = |fieldEn;
  assign allHit     = anyEnabled && (&fieldHit);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              secTick,
  input  logic              allHit,
  output fieldStrobe_t      strobe,
  output logic              flagQ,
  output logic              ieQ
);
  logic ctrlWrite;
  logic setFlag;
  logic clrFlag;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gDecode
    assign strobe.fieldLoad[i] = wrEn && (addr == ADDR_W'(i));
  end
  assign strobe.loadByte = wrData;

  assign ctrlWrite = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign setFlag   = secTick && allHit;
  assign clrFlag   = ctrlWrite && !wrData[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (setFlag) begin
      flagQ <= 1'b1;
    end else if (clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ <= 1'b0;
    end else if (ctrlWrite) begin
      ieQ <= wrData[IE_BIT];
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [TIME_W-1:0] timeFields,
  input  logic              secTick,
  output logic              alarmIrq
);
  fieldStrobe_t      strobe;
  logic [REGS_W-1:0] fieldRegs;
  logic              anyEnabled;
  logic              allHit;
  logic              flagQ;
  logic              ieQ;
  logic [DATA_W-1:0] ctrlByte;

  alarm_flag_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .secTick (secTick),
    .allHit  (allHit),
    .strobe  (strobe),
    .flagQ   (flagQ),
    .ieQ     (ieQ)
  );

  alarm_field_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .timeFields (timeFields),
    .fieldRegs  (fieldRegs),
    .anyEnabled (anyEnabled),
    .allHit     (allHit)
  );

  always_comb begin
    ctrlByte           = '0;
    ctrlByte[FLAG_BIT] = flagQ;
    ctrlByte[IE_BIT]   = ieQ;
  end

  always_comb begin
    if (int'(addr) < NUM_FIELDS) begin
      rdData = fieldRegs[int'(addr)*DATA_W +: DATA_W];
    end else if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdData = ctrlByte;
    end else begin
      rdData = '0;
    end
  end

  assign alarmIrq = flagQ && ieQ;
endmodule

// File: rtl/alarm_cmp_checker.sv
module alarm_cmp_checker
  import alarm_cmp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              secTick,
  input logic              allHit,
  input logic              anyEnabled,
  input logic              flagQ,
  input logic              ieQ,
  input logic              alarmIrq
);
  // R4: strobe with a full match sets the flag on the next cycle
  a_r4_set_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && allHit) |=> flagQ);

  // R6: the flag only rises after a strobe
  a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(secTick));

  // R7: with no field enabled the datapath never reports a match
  a_r7_no_enable_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !anyEnabled |-> !allHit);

  // R8: a clearing write without a strobe drops the flag
  a_r8_clear_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(CTRL_ADDR) && !wrData[FLAG_BIT] && !secTick) |=> !flagQ);

  // R9: set wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && allHit && wrEn && addr == ADDR_W'(CTRL_ADDR)) |=> flagQ);

  // R10: the interrupt never fires without both flag and enable
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> (flagQ && ieQ));
endmodule

bind alarm_cmp alarm_cmp_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .secTick    (secTick),
  .allHit     (allHit),
  .anyEnabled (anyEnabled),
  .flagQ      (flagQ),
  .ieQ        (ieQ),
  .alarmIrq   (alarmIrq)
);

// File: tb/alarm_cmp_test.sv
module alarm_cmp_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [41:0] timeFields = '0;
  logic        secTick = 1'b0;
  logic        alarmIrq;

  int checks = 0;
  int errors = 0;
  logic [6:0] pattern [6];

  alarm_cmp uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .timeFields(timeFields), .secTick(secTick), .alarmIrq(alarmIrq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setTime(input int pert);
    for (int f = 0; f < 6; f++) begin
      timeFields[f*7 +: 7] = (f == pert) ? (pattern[f] ^ 7'h01) : pattern[f];
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    pattern[0] = 7'h59; pattern[1] = 7'h30; pattern[2] = 7'h23;
    pattern[3] = 7'h06; pattern[4] = 7'h31; pattern[5] = 7'h12;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reset byte", v, 8'h00);
    end
    check("R1 irq after reset", {7'b0, alarmIrq}, 8'h00);

    // R2 readback of every alarm byte
    for (int a = 0; a < 6; a++) begin
      wr(3'(a), 8'hA5 ^ 8'(a * 17));
    end
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R2 alarm readback", v, 8'hA5 ^ 8'(a * 17));
    end

    // R3 control readback masks unused bits
    wr(3'd6, 8'hFF);
    rd(3'd6, v);
    check("R3 ctrl masked", v, 8'h08);
    rd(3'd7, v);
    check("R3 unused address", v, 8'h00);
    wr(3'd6, 8'h00);

    // R4 R5 R7 R11: sweep all enable masks, full match and single-field mismatches
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 6; f++) begin
        wr(3'(f), {m[f], pattern[f]});
      end
      for (int p = -1; p < 6; p++) begin
        logic expSet;
        setTime(p);
        expSet = (m != 0) && ((p < 0) || !m[p]);
        tick();
        rd(3'd6, v);
        if (m == 0) check("R7 no field enabled", {7'b0, v[0]}, 8'h00);
        else if (p < 0) check("R4 full match sets flag", {7'b0, v[0]}, 8'h01);
        else if (m[p]) check("R11 enabled mismatch", {7'b0, v[0]}, {7'b0, expSet});
        else check("R5 disabled field ignored", {7'b0, v[0]}, {7'b0, expSet});
        wr(3'd6, 8'h00);
      end
    end

    // R6 standing match without strobe
    for (int f = 0; f < 6; f++) wr(3'(f), {1'b1, pattern[f]});
    setTime(-1);
    repeat (5) @(negedge clk);
    rd(3'd6, v);
    check("R6 no tick no flag", v, 8'h00);

    // R8 writing 1 to flag bit while clear keeps it clear
    wr(3'd6, 8'h01);
    rd(3'd6, v);
    check("R8 write one no set", v, 8'h00);
    tick();
    wr(3'd6, 8'h09);
    rd(3'd6, v);
    check("R8 write one keeps flag", v, 8'h09);
    wr(3'd6, 8'h08);
    rd(3'd6, v);
    check("R8 write zero clears", v, 8'h08);

    // R10 interrupt gating
    check("R10 enable only", {7'b0, alarmIrq}, 8'h00);
    tick();
    #1;
    check("R10 flag and enable", {7'b0, alarmIrq}, 8'h01);
    wr(3'd6, 8'h01);
    #1;
    check("R10 flag only", {7'b0, alarmIrq}, 8'h00);

    // R9 set beats simultaneous clear
    @(negedge clk);
    secTick = 1'b1; wrEn = 1'b1; addr = 3'd6; wrData = 8'h00;
    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0;
    rd(3'd6, v);
    check("R9 set wins", v, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule